// File: doc/BRIEF.md
# Stop-Clock Handshake Sequencer

This block runs the power-down handshake of a 32-bit bus master. An active-low stop request arrives asynchronously and is synchronized first. The request waits behind every higher-priority event and behind any bus hold. Once the write buffers report empty, the block runs one special write-type bus cycle that carries a fixed acknowledge encoding. The system completes that cycle with a ready strobe, and the block then parks in a low-power grant state. In that state it keeps its bus outputs at their entry values, turns off the data drivers and the weak pull-up, and still yields the bus to a hold request. When the request is released, the block returns to idle and sends a one-cycle resume pulse to the core.

All pins are plain level control signals; no streaming data crosses this block, so it has no valid/ready port. The ready inputs `rdy` and `brdy` and the strobe `ads` are active high at this boundary. A separate monitor measures how long the request stays released after each completed acknowledge. It flags a sticky violation if the request comes back too soon.

Top module: `stop_clock_seq`

## Requirements
- R1: `stop_req_n` passes through a two-stage synchronizer. If it goes low between edges and all other conditions allow, `state` is still IDLE after the first and second rising edges and reads DRAIN after the third.
- R2: While `hold` or `hlda` is high, a request does not leave IDLE or DRAIN. Outside an active acknowledge cycle, `hlda` follows `hold` one edge later, and `bus_oe` is the inverse of `hlda`.
- R3: In DRAIN the block waits while `wbuf_empty` is 0. It enters CYCLE on the first edge that samples `wbuf_empty` at 1.
- R4: In CYCLE, `ads` is high for exactly one clock. The fields are `addr`=0x0000_0010, `be`=4'b1011, `m_io`=0, `d_c`=0 and `w_r`=1. `data_oe` is high during CYCLE and WAIT_ACK.
- R5: In WAIT_ACK the block stays put until `rdy` or `brdy` is sampled high. It then enters STOPPED on that edge.
- R6: In STOPPED, `ads` and `data_oe` are 0, and `addr`, `be`, `m_io`, `d_c` and `w_r` keep the values they had on entry.
- R7: If `hold` is high in STOPPED, the next edge gives HOLD_IN_STOP with `hlda`=1 and `bus_oe`=0. When `hold` drops, the next edge returns to STOPPED with `hlda`=0, `bus_oe`=1 and the address and control fields unchanged.
- R8: Releasing `stop_req_n` in STOPPED moves to IDLE on the third edge. `resume` is high for that one cycle only.
- R9: After an acknowledge completes, `gap_viol` rises if the synchronized request is released for fewer than 5 clocks before it returns. Once set, `gap_viol` stays high until reset.
- R10: `pullup_en` is 0 in STOPPED and HOLD_IN_STOP, and 1 in every other state.
- R11: A request does not leave IDLE while any bit of `evt_pend` is set. Bit 0 is reset, 1 flush, 2 SMI, 3 NMI and 4 INTR. Once all bits clear, the request proceeds on the next edge.
- R12: A synchronous active-low `rst_n` gives IDLE, `ads`=0, `hlda`=0, `data_oe`=0, `bus_oe`=1, `pullup_en`=1, `resume`=0 and `gap_viol`=0.
- R13: `state` encodes IDLE=0, DRAIN=1, CYCLE=2, WAIT_ACK=3, STOPPED=4 and HOLD_IN_STOP=5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stop_req_n | input | 1 | Asynchronous active-low stop request |
| evt_pend | input | 5 | Pending higher-priority events (reset, flush, SMI, NMI, INTR) |
| wbuf_empty | input | 1 | Write buffers drained |
| hold | input | 1 | Bus hold request |
| hlda | output | 1 | Hold acknowledge |
| rdy | input | 1 | Non-burst ready for the acknowledge cycle |
| brdy | input | 1 | Burst ready for the acknowledge cycle |
| ads | output | 1 | Address strobe, high for one clock |
| addr | output | 32 | Address field |
| be | output | 4 | Byte-enable field |
| m_io | output | 1 | Memory/IO select |
| d_c | output | 1 | Data/control select |
| w_r | output | 1 | Write/read select |
| data_oe | output | 1 | Data and parity output enable |
| bus_oe | output | 1 | Address and control output enable |
| pullup_en | output | 1 | Request-pin pull-up enable |
| resume | output | 1 | One-cycle resume pulse to the core |
| gap_viol | output | 1 | Sticky short-gap violation |
| state | output | 3 | Sequencer state code |

## Verification
A request applied between edges reaches DRAIN three edges later and CYCLE on the fourth. WAIT_ACK follows on the fifth edge. STOPPED comes on the edge that samples a ready. A release reaches IDLE with `resume` on the third edge. `hlda` and the pending-event, hold and buffer gates act one edge after the input changes. The bench drives inputs on falling edges, waits exactly that many falling edges and samples there. For the gap sweep over 1 to 7 released clocks, the flag is read well after its update edge, which is three edges past re-assertion.

// File: rtl/scs_pkg.sv
package scs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DRAIN = 3'd1,
    ST_CYCLE = 3'd2,
    ST_WAIT  = 3'd3,
    ST_STOP  = 3'd4,
    ST_HOLD  = 3'd5
  } scs_state_e;
endpackage

// File: rtl/scs_sync.sv
module scs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= async_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], async_i};
      end
    end
  endgenerate

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/scs_gap_mon.sv
module scs_gap_mon #(
  parameter int GAP_MIN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic ack_i,
  output logic viol_o
);
  localparam int CW = $clog2(GAP_MIN + 1);

  logic [CW-1:0] cnt;
  logic          armed;
  logic          req_d;
  logic          viol;
  logic          rise;

  assign rise = req_i & ~req_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
      req_d <= 1'b0;
      viol  <= 1'b0;
    end else begin
      req_d <= req_i;
      if (ack_i) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else if (armed) begin
        if (rise) begin
          armed <= 1'b0;
          if (cnt < CW'(GAP_MIN)) viol <= 1'b1;
        end else if (!req_i) begin
          if (cnt == CW'(GAP_MIN)) armed <= 1'b0;
          else                     cnt   <= cnt + 1'b1;
        end
      end
    end
  end

  assign viol_o = viol;
endmodule

// File: rtl/scs_fsm.sv
module scs_fsm
  import scs_pkg::*;
#(
  parameter int              ADDR_W   = 32,
  parameter int              BE_W     = 4,
  parameter logic [ADDR_W-1:0] ACK_ADDR = 'h10,
  parameter logic [BE_W-1:0]   ACK_BE   = 4'b1011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              evt_any,
  input  logic              wbuf_empty,
  input  logic              hold,
  input  logic              ack,
  output logic              hlda,
  output logic              ads,
  output logic [ADDR_W-1:0] addr,
  output logic [BE_W-1:0]   be,
  output logic              m_io,
  output logic              d_c,
  output logic              w_r,
  output logic              data_oe,
  output logic              bus_oe,
  output logic              pullup_en,
  output logic              resume,
  output logic              ack_done,
  output logic [2:0]        state
);
  scs_state_e        st, nx;
  logic              hlda_q, resume_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BE_W-1:0]   be_q;
  logic              mio_q, dc_q, wr_q;
  logic              defer;

  assign defer = hold | hlda_q | evt_any;

  always_comb begin
    nx = st;
    unique case (st)
      ST_IDLE:  if (req && !defer) nx = ST_DRAIN;
      ST_DRAIN: begin
        if (!req)                       nx = ST_IDLE;
        else if (wbuf_empty && !defer)  nx = ST_CYCLE;
      end
      ST_CYCLE: nx = ST_WAIT;
      ST_WAIT:  if (ack) nx = ST_STOP;
      ST_STOP: begin
        if (hold)      nx = ST_HOLD;
        else if (!req) nx = ST_IDLE;
      end
      ST_HOLD:  if (!hold) nx = ST_STOP;
      default:  nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      hlda_q   <= 1'b0;
      resume_q <= 1'b0;
      addr_q   <= '0;
      be_q     <= '1;
      mio_q    <= 1'b0;
      dc_q     <= 1'b0;
      wr_q     <= 1'b0;
    end else begin
      st       <= nx;
      hlda_q   <= (st == ST_CYCLE || st == ST_WAIT) ? 1'b0 : hold;
      resume_q <= (st == ST_STOP) && !hold && !req;
      if (st == ST_DRAIN && nx == ST_CYCLE) begin
        addr_q <= ACK_ADDR;
        be_q   <= ACK_BE;
        mio_q  <= 1'b0;
        dc_q   <= 1'b0;
        wr_q   <= 1'b1;
      end
    end
  end

  assign hlda      = hlda_q;
  assign bus_oe    = ~hlda_q;
  assign ads       = (st == ST_CYCLE);
  assign data_oe   = (st == ST_CYCLE) || (st == ST_WAIT);
  assign pullup_en = !((st == ST_STOP) || (st == ST_HOLD));
  assign resume    = resume_q;
  assign ack_done  = (st == ST_WAIT) && ack;
  assign addr      = addr_q;
  assign be        = be_q;
  assign m_io      = mio_q;
  assign d_c       = dc_q;
  assign w_r       = wr_q;
  assign state     = st;
endmodule

// File: rtl/stop_clock_seq.sv
module stop_clock_seq #(
  parameter int                ADDR_W      = 32,
  parameter int                BE_W        = 4,
  parameter int                NUM_EVT     = 5,
  parameter int                SYNC_STAGES = 2,
  parameter int                GAP_MIN     = 5,
  parameter logic [ADDR_W-1:0] ACK_ADDR    = 'h10,
  parameter logic [BE_W-1:0]   ACK_BE      = 4'b1011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_req_n,
  input  logic [NUM_EVT-1:0] evt_pend,
  input  logic              wbuf_empty,
  input  logic              hold,
  output logic              hlda,
  input  logic              rdy,
  input  logic              brdy,
  output logic              ads,
  output logic [ADDR_W-1:0] addr,
  output logic [BE_W-1:0]   be,
  output logic              m_io,
  output logic              d_c,
  output logic              w_r,
  output logic              data_oe,
  output logic              bus_oe,
  output logic              pullup_en,
  output logic              resume,
  output logic              gap_viol,
  output logic [2:0]        state
);
  logic req_s;
  logic ack_done;

  scs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (~stop_req_n),
    .sync_o  (req_s)
  );

  scs_fsm #(
    .ADDR_W   (ADDR_W),
    .BE_W     (BE_W),
    .ACK_ADDR (ACK_ADDR),
    .ACK_BE   (ACK_BE)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req_s),
    .evt_any    (|evt_pend),
    .wbuf_empty (wbuf_empty),
    .hold       (hold),
    .ack        (rdy | brdy),
    .hlda       (hlda),
    .ads        (ads),
    .addr       (addr),
    .be         (be),
    .m_io       (m_io),
    .d_c        (d_c),
    .w_r        (w_r),
    .data_oe    (data_oe),
    .bus_oe     (bus_oe),
    .pullup_en  (pullup_en),
    .resume     (resume),
    .ack_done   (ack_done),
    .state      (state)
  );

  scs_gap_mon #(.GAP_MIN(GAP_MIN)) u_gap (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (req_s),
    .ack_i  (ack_done),
    .viol_o (gap_viol)
  );
endmodule

// File: rtl/stop_clock_seq_chk.sv
module stop_clock_seq_chk #(
  parameter int                ADDR_W   = 32,
  parameter int                BE_W     = 4,
  parameter logic [ADDR_W-1:0] ACK_ADDR = 'h10,
  parameter logic [BE_W-1:0]   ACK_BE   = 4'b1011
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rdy,
  input logic              brdy,
  input logic              hold,
  input logic              hlda,
  input logic              ads,
  input logic [ADDR_W-1:0] addr,
  input logic [BE_W-1:0]   be,
  input logic              m_io,
  input logic              d_c,
  input logic              w_r,
  input logic              data_oe,
  input logic              bus_oe,
  input logic              pullup_en,
  input logic              resume,
  input logic              gap_viol,
  input logic [2:0]        state
);
  localparam logic [2:0] S_WAIT = 3'd3;
  localparam logic [2:0] S_STOP = 3'd4;

  p_hold_blocks_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> !ads);

  p_ads_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ads |=> !ads);

  p_ack_fields_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ads |-> (addr == ACK_ADDR && be == ACK_BE && !m_io && !d_c && w_r && data_oe));

  p_stop_needs_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STOP && $past(state) == S_WAIT) |-> $past(rdy | brdy));

  p_stopped_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STOP) |-> (!ads && !data_oe));

  p_stopped_hold_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STOP && $past(state) == S_STOP) |-> ($stable(addr) && $stable(be)));

  p_hlda_floats_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> !bus_oe);

  p_resume_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> !resume);

  p_viol_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    gap_viol |=> gap_viol);

  p_pullup_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STOP) |-> !pullup_en);
endmodule

bind stop_clock_seq stop_clock_seq_chk #(
  .ADDR_W   (ADDR_W),
  .BE_W     (BE_W),
  .ACK_ADDR (ACK_ADDR),
  .ACK_BE   (ACK_BE)
) u_chk (.*);

// File: tb/stop_clock_seq_tb.sv
`timescale 1ns/1ps
module stop_clock_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n, stop_req_n, wbuf_empty, hold, rdy, brdy;
  logic [4:0]  evt_pend;
  logic        hlda, ads, m_io, d_c, w_r, data_oe, bus_oe, pullup_en, resume, gap_viol;
  logic [31:0] addr;
  logic [3:0]  be;
  logic [2:0]  state;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  stop_clock_seq u_dut (
    .clk(clk), .rst_n(rst_n), .stop_req_n(stop_req_n), .evt_pend(evt_pend),
    .wbuf_empty(wbuf_empty), .hold(hold), .hlda(hlda), .rdy(rdy), .brdy(brdy),
    .ads(ads), .addr(addr), .be(be), .m_io(m_io), .d_c(d_c), .w_r(w_r),
    .data_oe(data_oe), .bus_oe(bus_oe), .pullup_en(pullup_en), .resume(resume),
    .gap_viol(gap_viol), .state(state)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; stop_req_n = 1'b1; hold = 1'b0; rdy = 1'b0; brdy = 1'b0;
    wbuf_empty = 1'b1; evt_pend = '0;
    step(3);
    rst_n = 1'b1;
    step(1);
  endtask

  // Request to STOPPED with the exact edge count of each transition.
  task automatic to_stop(input bit use_brdy);
    stop_req_n = 1'b0;
    step(1); check("R1 idle after edge1", state, 0);
    step(1); check("R1 idle after edge2", state, 0);
    step(1); check("R1 R13 drain after edge3", state, 1);
    step(1);
    check("R13 cycle state", state, 2);
    check("R4 ads high", ads, 1);
    check("R4 addr", addr, 32'h10);
    check("R4 be", be, 4'b1011);
    check("R4 mio/dc/wr", {m_io, d_c, w_r}, 3'b001);
    check("R4 data_oe in cycle", data_oe, 1);
    step(1);
    check("R4 ads one cycle", ads, 0);
    check("R13 wait state", state, 3);
    step(2);
    check("R5 wait holds without ready", state, 3);
    if (use_brdy) brdy = 1'b1; else rdy = 1'b1;
    step(1);
    rdy = 1'b0; brdy = 1'b0;
    check("R5 R13 stopped after ready", state, 4);
    check("R6 data_oe off", data_oe, 0);
    check("R6 ads off", ads, 0);
    check("R6 addr kept", addr, 32'h10);
    check("R6 be kept", be, 4'b1011);
    check("R10 pullup off", pullup_en, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired (all requirements)");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; stop_req_n = 1'b1; hold = 1'b0; rdy = 1'b0; brdy = 1'b0;
    wbuf_empty = 1'b1; evt_pend = '0;
    do_reset();
    check("R12 state", state, 0);
    check("R12 ads/hlda/data_oe/resume/viol", {ads, hlda, data_oe, resume, gap_viol}, 5'b0);
    check("R12 bus_oe/pullup", {bus_oe, pullup_en}, 2'b11);

    // R11: each pending event defers the request.
    for (int i = 0; i < 5; i++) begin
      do_reset();
      evt_pend = 5'(1 << i);
      stop_req_n = 1'b0;
      step(5);
      check("R11 deferred by pending event", state, 0);
      evt_pend = '0;
      step(1);
      check("R11 proceeds after clear", state, 1);
    end

    // R2: hold blocks the request.
    do_reset();
    hold = 1'b1;
    step(1);
    check("R2 hlda follows hold", hlda, 1);
    check("R2 bus_oe off in hold", bus_oe, 0);
    stop_req_n = 1'b0;
    step(5);
    check("R2 idle under hold", state, 0);
    hold = 1'b0;
    step(1);
    check("R2 hlda drops", hlda, 0);
    check("R2 still idle while hlda was high", state, 0);
    step(1);
    check("R2 proceeds after hold", state, 1);

    // R3: write buffers not drained.
    do_reset();
    wbuf_empty = 1'b0;
    stop_req_n = 1'b0;
    step(6);
    check("R3 waits in drain", state, 1);
    wbuf_empty = 1'b1;
    step(1);
    check("R3 cycle after drain", state, 2);

    // Main: hold while stopped, then release.
    do_reset();
    to_stop(1'b0);
    hold = 1'b1;
    step(1);
    check("R7 R13 hold in stop", state, 5);
    check("R7 hlda in stop", hlda, 1);
    check("R7 bus floated", bus_oe, 0);
    check("R10 pullup off in hold", pullup_en, 0);
    step(2);
    check("R7 stays in hold", state, 5);
    hold = 1'b0;
    step(1);
    check("R7 back to stopped", state, 4);
    check("R7 hlda low", hlda, 0);
    check("R7 bus driven", bus_oe, 1);
    check("R7 fields restored", {addr, be, m_io, d_c, w_r}, {32'h10, 4'b1011, 3'b001});
    stop_req_n = 1'b1;
    step(1); check("R8 stopped after edge1", state, 4);
    step(1); check("R8 stopped after edge2", state, 4);
    step(1);
    check("R8 idle after edge3", state, 0);
    check("R8 resume high", resume, 1);
    check("R10 pullup back on", pullup_en, 1);
    step(1);
    check("R8 resume one cycle", resume, 0);
    step(10);
    check("R9 no violation without reassert", gap_viol, 0);

    // R9: sweep the released gap length.
    for (int k = 1; k <= 7; k++) begin
      do_reset();
      to_stop(k[0]);
      stop_req_n = 1'b1;
      step(k);
      stop_req_n = 1'b0;
      step(6);
      check("R9 gap flag", gap_viol, (k < 5) ? 1 : 0);
      step(5);
      check("R9 gap flag sticky", gap_viol, (k < 5) ? 1 : 0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule